// File: doc/BRIEF.md
# Blocked Thread Wakeup Table

This block sits beside the issue scheduler of a multithreaded core. When a thread starts a long-latency send, receive or load, the core reports it on the allocation port. The block records the thread in a small fully associative table and clears that thread's bit in a ready vector, so the scheduler stops picking it. Its register context stays where it is. Later the network side delivers a data or acknowledge notification tagged with source and destination thread IDs. An entry that matches sets the thread's ready bit again and frees itself, so no interrupt is taken.

Notifications are screened first by a source/destination permission matrix. Data that arrives before its receive has been posted is kept as an early-arrival entry, and the later receive consumes it without sleeping. When no slot can take a new record, a miss request names the thread that the operating system must handle. Victims are taken from computation threads before communication threads.

Top module: `thread_wake_table`

## Requirements
- R1: After reset every bit of `ready_vec` is 1, the table is empty (`empty`=1, `full`=0), `active_cnt` equals NTHR and every permission bit denies.
- R2: An allocation (`alloc_kind` 0=send, 1=receive, 2=load) that is not absorbed by an early-arrival entry clears `ready_vec[alloc_tid]` on the next edge. For a receive, `alloc_peer` is the expected sender.
- R3: An acknowledge (`ntf_kind`=1) wakes a thread only through a send entry whose thread equals `ntf_dst`. The ready bit rises on the next edge and the entry is freed. Data notifications never wake a send entry.
- R4: A data notification (`ntf_kind`=0) wakes a receive entry only when the entry's thread equals `ntf_dst` and its peer equals `ntf_src`. It wakes a load entry on `ntf_dst` alone.
- R5: A permitted data notification that matches nothing is stored as an early-arrival entry (thread `ntf_dst`, peer `ntf_src`). A later receive with the same thread and peer frees that entry and leaves the ready bit set.
- R6: A notification whose bit `perm[src][dst]` is 0 has no effect on the table, the ready vector or the miss output. `perm_we` writes `perm_allow` into that bit on the next edge.
- R7: An unmatched acknowledge, or a new record that finds no usable slot, pulses `miss_req` for one cycle after the edge, with `miss_tid` set to the thread concerned.
- R8: When the table is full, a new record replaces the lowest-index computation entry. If no computation entry exists, it replaces the lowest-index entry only when the new thread is a communication thread (`comm_cfg` bit 1). Otherwise it is refused. An evicted entry raises `miss_req` with its own thread ID.
- R9: `full` is 1 when all NTHR entries hold records, `empty` is 1 when none does, and `active_cnt` counts the set bits of `ready_vec`.
- R10: `ntf_ready` is 0 while `alloc_valid` is 1 for a thread other than `ntf_dst`. When both ports name the same thread, the notification is taken and the allocation is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| comm_cfg | input | NTHR | Per-thread flag: 1 marks a communication thread |
| alloc_valid | input | 1 | A thread begins a blocking operation |
| alloc_tid | input | TW | Blocking thread |
| alloc_kind | input | 2 | 0 send, 1 receive, 2 load |
| alloc_peer | input | TW | Expected sender for a receive |
| ntf_valid | input | 1 | Notification present |
| ntf_ready | output | 1 | Notification accepted this cycle |
| ntf_kind | input | 1 | 0 data arrival, 1 acknowledge |
| ntf_src | input | TW | Source thread of the notification |
| ntf_dst | input | TW | Destination thread of the notification |
| perm_we | input | 1 | Permission write strobe |
| perm_src | input | TW | Source of the pair written |
| perm_dst | input | TW | Destination of the pair written |
| perm_allow | input | 1 | Value written |
| ready_vec | output | NTHR | Scheduler candidate mask |
| miss_req | output | 1 | One-cycle request for operating system help |
| miss_tid | output | TW | Thread named by the miss |
| full | output | 1 | All entries in use |
| empty | output | 1 | No entry in use |
| active_cnt | output | CW | Number of ready threads |

## Verification
Every thread is put to sleep with each kind of operation. Each one then receives first a near-miss notification and then the exact one. The near-miss is data to a send, data from the wrong peer to a receive, or an acknowledge to a load, and it separates the three matching rules from one another. The near-misses that leave early-arrival records are then consumed by receives, which shows that the record holds the right peer. Permission is tried both denied and allowed on the same pair. Two full-table scenarios separate victim choice by thread class: one mixes communication and computation entries, the other holds only communication entries. Paired simultaneous allocations and notifications, to different threads and to the same thread, separate the back-pressure rule from the wakeup-wins rule.

// File: rtl/thread_wake_table.sv
module thread_wake_table #(
  parameter int NTHR = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NTHR-1:0]               comm_cfg,
  input  logic                          alloc_valid,
  input  logic [$clog2(NTHR)-1:0]       alloc_tid,
  input  logic [1:0]                    alloc_kind,
  input  logic [$clog2(NTHR)-1:0]       alloc_peer,
  input  logic                          ntf_valid,
  output logic                          ntf_ready,
  input  logic                          ntf_kind,
  input  logic [$clog2(NTHR)-1:0]       ntf_src,
  input  logic [$clog2(NTHR)-1:0]       ntf_dst,
  input  logic                          perm_we,
  input  logic [$clog2(NTHR)-1:0]       perm_src,
  input  logic [$clog2(NTHR)-1:0]       perm_dst,
  input  logic                          perm_allow,
  output logic [NTHR-1:0]               ready_vec,
  output logic                          miss_req,
  output logic [$clog2(NTHR)-1:0]       miss_tid,
  output logic                          full,
  output logic                          empty,
  output logic [$clog2(NTHR+1)-1:0]     active_cnt
);
  localparam int TW = $clog2(NTHR);
  localparam int CW = $clog2(NTHR+1);
  localparam logic [1:0] K_SEND = 2'd0, K_RECV = 2'd1;

  logic [NTHR-1:0]      ev, eearly, ecomm, rdy;
  logic [1:0]           ekind [NTHR];
  logic [TW-1:0]        etid  [NTHR];
  logic [TW-1:0]        epeer [NTHR];
  logic [NTHR*NTHR-1:0] perm;
  logic                 miss_q;
  logic [TW-1:0]        mtid_q;

  logic [NTHR-1:0]      nv, nearly, ncomm, nrdy;
  logic [1:0]           nkind [NTHR];
  logic [TW-1:0]        ntid  [NTHR];
  logic [TW-1:0]        npeer [NTHR];
  logic                 nmiss;
  logic [TW-1:0]        nmt;

  function automatic logic [TW-1:0] first_set(input logic [NTHR-1:0] m);
    first_set = '0;
    for (int i = NTHR-1; i >= 0; i--)
      if (m[i]) first_set = TW'(i);
  endfunction

  assign ntf_ready  = !alloc_valid || (alloc_tid == ntf_dst);
  wire   acc        = ntf_valid && ntf_ready;
  wire   perm_ok    = perm[int'(ntf_src)*NTHR + int'(ntf_dst)];

  logic [NTHR-1:0] hit, ehit;
  always_comb begin
    for (int i = 0; i < NTHR; i++) begin
      hit[i]  = ev[i] && !eearly[i] && etid[i] == ntf_dst &&
                (ntf_kind ? ekind[i] == K_SEND
                          : (ekind[i] == 2'd2 || (ekind[i] == K_RECV && epeer[i] == ntf_src)));
      ehit[i] = ev[i] && eearly[i] && etid[i] == alloc_tid && epeer[i] == alloc_peer;
    end
  end

  wire [NTHR-1:0] free_m  = ~ev;
  wire [NTHR-1:0] comp_m  = ev & ~ecomm;
  wire            c_new   = acc ? comm_cfg[ntf_dst] : comm_cfg[alloc_tid];
  wire            slot_ok = (|free_m) || (|comp_m) || c_new;
  wire            evict   = ~|free_m;
  wire [TW-1:0]   sidx    = (|free_m) ? first_set(free_m)
                          : (|comp_m) ? first_set(comp_m) : '0;

  logic          wr, wearly;
  logic [TW-1:0] wtid, wpeer;
  logic [1:0]    wkind;

  always_comb begin
    nv = ev; nearly = eearly; ncomm = ecomm; nrdy = rdy;
    nkind = ekind; ntid = etid; npeer = epeer;
    nmiss = 1'b0; nmt = '0;
    wr = 1'b0; wearly = 1'b0; wtid = '0; wpeer = '0; wkind = K_SEND;
    if (acc) begin
      if (perm_ok) begin
        if (|hit) begin
          nv[first_set(hit)] = 1'b0;
          nrdy[ntf_dst] = 1'b1;
        end else if (!ntf_kind) begin
          wr = 1'b1; wearly = 1'b1; wtid = ntf_dst; wpeer = ntf_src; wkind = K_RECV;
        end else begin
          nmiss = 1'b1; nmt = ntf_dst;
        end
      end
    end else if (alloc_valid) begin
      if (alloc_kind == K_RECV && |ehit) begin
        nv[first_set(ehit)] = 1'b0;
      end else begin
        nrdy[alloc_tid] = 1'b0;
        wr = 1'b1; wtid = alloc_tid; wpeer = alloc_peer; wkind = alloc_kind;
      end
    end
    if (wr) begin
      if (!slot_ok) begin
        nmiss = 1'b1; nmt = wtid;
      end else begin
        if (evict) begin nmiss = 1'b1; nmt = etid[sidx]; end
        nv[sidx] = 1'b1; nearly[sidx] = wearly; ncomm[sidx] = c_new;
        nkind[sidx] = wkind; ntid[sidx] = wtid; npeer[sidx] = wpeer;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ev <= '0; eearly <= '0; ecomm <= '0; rdy <= '1; perm <= '0;
      miss_q <= 1'b0; mtid_q <= '0;
      for (int i = 0; i < NTHR; i++) begin
        ekind[i] <= K_SEND; etid[i] <= '0; epeer[i] <= '0;
      end
    end else begin
      ev <= nv; eearly <= nearly; ecomm <= ncomm; rdy <= nrdy;
      ekind <= nkind; etid <= ntid; epeer <= npeer;
      miss_q <= nmiss; mtid_q <= nmt;
      if (perm_we) perm[int'(perm_src)*NTHR + int'(perm_dst)] <= perm_allow;
    end
  end

  assign ready_vec  = rdy;
  assign miss_req   = miss_q;
  assign miss_tid   = mtid_q;
  assign full       = &ev;
  assign empty      = ~|ev;
  assign active_cnt = CW'($countones(rdy));
endmodule

// File: rtl/thread_wake_table_chk.sv
module thread_wake_table_chk #(
  parameter int NTHR = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    alloc_valid,
  input logic [$clog2(NTHR)-1:0] alloc_tid,
  input logic [1:0]              alloc_kind,
  input logic                    ntf_valid,
  input logic                    ntf_ready,
  input logic [$clog2(NTHR)-1:0] ntf_src,
  input logic [$clog2(NTHR)-1:0] ntf_dst,
  input logic [NTHR-1:0]         ready_vec,
  input logic                    miss_req,
  input logic [NTHR*NTHR-1:0]    perm
);
  // R6
  denied_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ntf_valid && ntf_ready && !alloc_valid && !perm[int'(ntf_src)*NTHR + int'(ntf_dst)])
      |=> ($stable(ready_vec) && !miss_req));

  // R3
  wake_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ready_vec & ~$past(ready_vec)) != '0) |-> $past(ntf_valid && ntf_ready));

  // R2
  sleep_on_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && !(ntf_valid && ntf_ready) && alloc_kind != 2'd1)
      |=> !ready_vec[$past(alloc_tid)]);

  // R7
  miss_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss_req |-> $past(ntf_valid || alloc_valid));
endmodule

bind thread_wake_table thread_wake_table_chk #(.NTHR(NTHR)) u_chk (.*);

// File: tb/sim_thread_wake_table.sv
module sim_thread_wake_table;
  localparam int N = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] comm_cfg = '0;
  logic alloc_valid = 0, ntf_valid = 0, ntf_kind = 0, perm_we = 0, perm_allow = 0;
  logic [1:0] alloc_tid = 0, alloc_peer = 0, ntf_src = 0, ntf_dst = 0, perm_src = 0, perm_dst = 0;
  logic [1:0] alloc_kind = 0;
  logic ntf_ready, miss_req, full, empty;
  logic [N-1:0] ready_vec;
  logic [1:0] miss_tid;
  logic [2:0] active_cnt;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  thread_wake_table #(.NTHR(N)) u0 (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ceq(input string req, input int act, input int exp);
    check(act == exp, req, act, exp);
  endtask

  task automatic edge_done();
    @(posedge clk); #1;
    alloc_valid = 0; ntf_valid = 0; perm_we = 0;
  endtask

  task automatic alloc(input int t, input int k, input int p);
    @(negedge clk);
    alloc_valid = 1; alloc_tid = 2'(t); alloc_kind = 2'(k); alloc_peer = 2'(p);
    edge_done();
  endtask

  task automatic notify(input bit k, input int s, input int d);
    @(negedge clk);
    ntf_valid = 1; ntf_kind = k; ntf_src = 2'(s); ntf_dst = 2'(d);
    edge_done();
  endtask

  task automatic setperm(input int s, input int d, input bit a);
    @(negedge clk);
    perm_we = 1; perm_src = 2'(s); perm_dst = 2'(d); perm_allow = a;
    edge_done();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    ceq("R1 ready", int'(ready_vec), 15);
    ceq("R1 empty", int'(empty), 1);
    ceq("R1 full", int'(full), 0);
    ceq("R1 count", int'(active_cnt), 4);
    ceq("R1 miss", int'(miss_req), 0);
    // R1/R6 permissions deny after reset
    alloc(0, 1, 1);
    notify(0, 1, 0);
    ceq("R6 deny keeps sleep", int'(ready_vec[0]), 0);
    ceq("R6 deny no miss", int'(miss_req), 0);
    for (int s = 0; s < N; s++)
      for (int d = 0; d < N; d++) setperm(s, d, 1);
    notify(0, 1, 0);
    ceq("R6 allowed wakes", int'(ready_vec[0]), 1);
    ceq("R6 no early record from denied", int'(empty), 1);

    // Sweep over threads and kinds: R2 R3 R4 R5 R7 R9
    for (int t = 0; t < N; t++) begin
      for (int k = 0; k < 3; k++) begin
        int p = (t + 1) % N;
        int q = (t + 2) % N;
        alloc(t, k, p);
        ceq("R2 sleep", int'(ready_vec[t]), 0);
        ceq("R9 count", int'(active_cnt), 3);
        ceq("R9 not empty", int'(empty), 0);
        if (k == 0) begin
          notify(0, p, t);
          ceq("R3 data ignores send", int'(ready_vec[t]), 0);
          notify(1, p, t);
          ceq("R3 ack wakes", int'(ready_vec[t]), 1);
          ceq("R3 no miss", int'(miss_req), 0);
          alloc(t, 1, p);
        end else if (k == 1) begin
          notify(0, q, t);
          ceq("R4 wrong peer", int'(ready_vec[t]), 0);
          notify(0, p, t);
          ceq("R4 right peer", int'(ready_vec[t]), 1);
          alloc(t, 1, q);
        end else begin
          notify(1, p, t);
          ceq("R7 ack miss", int'(miss_req), 1);
          ceq("R7 miss tid", int'(miss_tid), t);
          ceq("R4 load stays", int'(ready_vec[t]), 0);
          notify(0, q, t);
          ceq("R4 load wakes", int'(ready_vec[t]), 1);
        end
        ceq("R5 early consumed ready", int'(ready_vec[t]), 1);
        ceq("R5 early consumed empty", int'(empty), 1);
      end
    end

    // R6 single pair denied then allowed
    setperm(2, 1, 0);
    alloc(1, 1, 2);
    notify(0, 2, 1);
    ceq("R6 pair denied", int'(ready_vec[1]), 0);
    setperm(2, 1, 1);
    notify(0, 2, 1);
    ceq("R6 pair allowed", int'(ready_vec[1]), 1);
    ceq("R6 empty after", int'(empty), 1);

    // R10 handshake
    alloc(0, 2, 0);
    @(negedge clk);
    alloc_valid = 1; alloc_tid = 1; alloc_kind = 0; alloc_peer = 2;
    ntf_valid = 1; ntf_kind = 0; ntf_src = 1; ntf_dst = 0;
    #1 ceq("R10 held off", int'(ntf_ready), 0);
    edge_done();
    ceq("R10 alloc taken", int'(ready_vec[1]), 0);
    ceq("R10 ntf not taken", int'(ready_vec[0]), 0);
    notify(1, 2, 1);
    ceq("R10 t1 woken", int'(ready_vec[1]), 1);
    @(negedge clk);
    alloc_valid = 1; alloc_tid = 0; alloc_kind = 0; alloc_peer = 3;
    ntf_valid = 1; ntf_kind = 0; ntf_src = 1; ntf_dst = 0;
    #1 ceq("R10 same thread ready", int'(ntf_ready), 1);
    edge_done();
    ceq("R10 wakeup wins", int'(ready_vec[0]), 1);
    ceq("R10 alloc dropped", int'(empty), 1);

    // R8 mixed classes: threads 0,1 communication
    comm_cfg = 4'b0011;
    for (int d = 0; d < N; d++) notify(0, 3, d);
    ceq("R9 full", int'(full), 1);
    ceq("R8 fill no miss", int'(miss_req), 0);
    notify(0, 2, 3);
    ceq("R8 comp victim miss", int'(miss_req), 1);
    ceq("R8 comp victim tid", int'(miss_tid), 2);
    alloc(2, 1, 3);
    ceq("R8 evicted record gone", int'(ready_vec[2]), 0);
    ceq("R8 second victim tid", int'(miss_tid), 3);
    notify(0, 3, 2);
    ceq("R8 t2 woken", int'(ready_vec[2]), 1);
    alloc(0, 1, 3);
    alloc(1, 1, 3);
    alloc(3, 1, 3);
    ceq("R8 comm records kept", int'(ready_vec), 15);
    ceq("R8 drained", int'(empty), 1);

    // R8 all communication entries, computation newcomer refused
    comm_cfg = 4'b1110;
    notify(0, 3, 1); notify(0, 3, 2); notify(0, 3, 3); notify(0, 2, 1);
    ceq("R9 full again", int'(full), 1);
    alloc(0, 0, 1);
    ceq("R8 refused miss", int'(miss_req), 1);
    ceq("R8 refused tid", int'(miss_tid), 0);
    ceq("R8 refused sleeps", int'(ready_vec[0]), 0);
    ceq("R8 still full", int'(full), 1);
    alloc(1, 1, 3);
    ceq("R8 comm entry survived", int'(ready_vec[1]), 1);
    ceq("R8 not full", int'(full), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule